// File: doc/BRIEF.md
# SMBus Command Bridge to an 8-bit Peripheral Bus

This block sits behind an SMBus target that has already decoded a write-byte or read-byte transfer. Each transfer reaches the bridge as a one-cycle start strobe carrying three things: the command code, the data byte and the transfer direction. The upper nibble of the command code picks a destination. The destination can be the bridge's own small register file, a character-display controller reached on chip select 1, or one of four generic chip selects. On the peripheral bus the lower nibble becomes the address. When a transfer goes out on the bus, the bridge runs a fixed cycle: setup, then strobe, then hold. It returns a one-cycle completion pulse together with any byte read back.

A second host also drives the same peripheral bus. Bus ownership passes through a request/grant arbiter. A grant is given only when the bus is idle, and the owner keeps the bus until it drops its request. A register inside the bridge decides whether the SMBus side may use the peripheral bus at all. Any command that is undefined, disallowed or inconsistent completes at once with the error flag set. Such a command changes no register and starts no bus cycle.

Top module: `smb_pbus_bridge`

## Requirements
- R1: Upper nibble 0000 with a lower nibble (index) from 0x0 to 0xB accesses internal register `index`. A write stores the data byte. A read returns the stored byte on `cmd_rdata`. `cmd_done` pulses one cycle after the start strobe, with `cmd_error` low, and no chip select is asserted.
- R2: Upper nibble 0000 with index 0xC to 0xF completes with `cmd_done` and `cmd_error` both high. No register changes and no chip select is asserted.
- R3: Upper nibbles 0010, 0011, 0100 and 0101 run a bus cycle in either direction. During that cycle the bridge asserts `xb_cs` bit 0, 1, 2 or 3 respectively (active high) and holds `xb_addr` equal to the lower nibble.
- R4: Upper nibble 0001 is display mode. It asserts `xb_cs` bit 1, and `xb_addr` carries the lower nibble, whose bits 1:0 act as the display A1/A0 lines. `xb_lcd_stb` is high exactly during the strobe phase of such a cycle and never otherwise.
- R5: In display mode, command bit 0 gives the direction (1 = read, 0 = write). If it differs from `cmd_read`, the command completes with `cmd_error` and no bus cycle takes place.
- R6: Upper nibbles 0110 to 1111 complete with `cmd_error` and no bus cycle.
- R7: A bus cycle consists of exactly 2 setup cycles with chip select and address and no strobe, then 4 cycles with strobe `xb_rd_n` (read) or `xb_wr_n` (write) low, then 1 hold cycle. On a read, `xb_din` is sampled on the last strobe cycle and presented on `cmd_rdata` with `cmd_done`.
- R8: `xb_doe` is high only during write cycles, for the whole time chip select is asserted. While it is high, `xb_dout` equals the data byte.
- R9: `xb_cs` is one-hot or all zero. A strobe is never low without a chip select.
- R10: `host2_gnt` is given only when the bus is idle. While the second host holds the grant, no SMBus cycle starts. Once a cycle has begun, it is never interrupted by a request from the second host.
- R11: If the SMBus side and the second host request in the same clock, the SMBus side is granted.
- R12: Internal register 2, bit 0, enables peripheral-bus access for the SMBus side, and it resets to 1. While it is 0, every command that would use the bus completes with `cmd_error` and no cycle.
- R13: After reset the bridge shows no chip select, both strobes high, `xb_doe`, `xb_lcd_stb`, `cmd_done`, `cmd_error` and `host2_gnt` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | One-cycle start strobe from the SMBus target |
| cmd_code | input | 8 | SMBus command code |
| cmd_wdata | input | 8 | Data byte for writes |
| cmd_read | input | 1 | Transfer direction, 1 = read |
| cmd_done | output | 1 | Completion pulse |
| cmd_error | output | 1 | Command ignored, valid with `cmd_done` |
| cmd_rdata | output | 8 | Byte read back, valid with `cmd_done` |
| host2_req | input | 1 | Bus request from the second host |
| host2_gnt | output | 1 | Bus grant to the second host |
| xb_cs | output | 4 | Chip selects, active high |
| xb_addr | output | 4 | Peripheral address |
| xb_rd_n | output | 1 | Read strobe, active low |
| xb_wr_n | output | 1 | Write strobe, active low |
| xb_lcd_stb | output | 1 | Combined display strobe, active high |
| xb_dout | output | 8 | Write data toward the bus |
| xb_doe | output | 1 | Output enable for `xb_dout` |
| xb_din | input | 8 | Read data from the bus |

## Verification
The hardest case to reach is a same-clock tie between the two requesters. The SMBus side raises its request only one clock after the start strobe, so the bench raises `host2_req` at exactly that clock. It then checks that the second host stays ungranted through the whole cycle and is granted after completion. The bench reaches the opposite situation, an SMBus command held off while the second host owns the bus, by holding the grant for a dozen cycles before releasing it. The bench puts valid read data on `xb_din` only during the fourth strobe cycle, which pins down the capture point.

// File: rtl/smb_pbus_pkg.sv
package smb_pbus_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_WAIT,
        SEQ_SETUP,
        SEQ_STROBE,
        SEQ_HOLD
    } seq_state_e;

    typedef enum logic [1:0] {
        OWN_NONE,
        OWN_SMB,
        OWN_HOST2
    } bus_owner_e;

    typedef enum logic [1:0] {
        TGT_REGS,
        TGT_BUS,
        TGT_REJECT
    } target_e;

endpackage

// File: rtl/smb_cmd_decode.sv
module smb_cmd_decode
    import smb_pbus_pkg::*;
#(
    parameter int AW        = 4,
    parameter int NCS       = 4,
    parameter int NREGS     = 12,
    parameter int REG_NIB   = 0,
    parameter int LCD_NIB   = 1,
    parameter int LCD_CS    = 1,
    parameter int CS_BASE   = 2
) (
    input  logic [2*AW-1:0] code,
    input  logic            is_read,
    input  logic            bus_enable,
    output target_e         target,
    output logic            lcd_mode,
    output logic [NCS-1:0]  cs_onehot,
    output logic [AW-1:0]   index
);

    logic [AW-1:0] hi_nib;
    logic          hit_regs;
    logic          hit_lcd;
    logic          hit_gen;
    logic          bus_ok;

    assign hi_nib = code[2*AW-1:AW];
    assign index  = code[AW-1:0];

    always_comb begin
        hit_regs = (int'(hi_nib) == REG_NIB) && (int'(index) < NREGS);
        hit_lcd  = (int'(hi_nib) == LCD_NIB) && (code[0] == is_read);
        hit_gen  = (int'(hi_nib) >= CS_BASE) && (int'(hi_nib) < CS_BASE + NCS);
        bus_ok   = (hit_lcd || hit_gen) && bus_enable;
        if (hit_regs)    target = TGT_REGS;
        else if (bus_ok) target = TGT_BUS;
        else             target = TGT_REJECT;
        lcd_mode = hit_lcd;
    end

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign cs_onehot[g] = (hit_gen && (int'(hi_nib) == CS_BASE + g)) ||
                              (hit_lcd && (g == LCD_CS));
    end

    // R9: at most one chip select chosen; bus targets always pick one
    always_comb begin
        if (!$isunknown(code) && !$isunknown(is_read) && !$isunknown(bus_enable)) begin
            p_decode_onehot_r9: assert ($onehot0(cs_onehot));
            p_decode_bus_has_cs_r3: assert (target != TGT_BUS || cs_onehot != '0);
        end
    end

endmodule

// File: rtl/smb_ctrl_regs.sv
module smb_ctrl_regs #(
    parameter int          DW      = 8,
    parameter int          AW      = 4,
    parameter int          NREGS   = 12,
    parameter int          ARB_IDX = 2,
    parameter logic [DW-1:0] ARB_RST = 8'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          bus_enable
);

    logic [DW-1:0] regs_d [NREGS];
    logic [DW-1:0] regs_q [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_d[i] = regs_q[i];
            if (wr_en && int'(wr_idx) == i) regs_d[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++)
                regs_q[i] <= (i == ARB_IDX) ? ARB_RST : '0;
        end else begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= regs_d[i];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREGS; i++)
            if (int'(rd_idx) == i) rd_data = regs_q[i];
    end

    assign bus_enable = regs_q[ARB_IDX][0];

    // R2: writes only ever reach defined indices
    p_write_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NREGS));

endmodule

// File: rtl/smb_bus_arbiter.sv
module smb_bus_arbiter
    import smb_pbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smb_req,
    input  logic host2_req,
    output logic smb_gnt,
    output logic host2_gnt
);

    bus_owner_e owner_d, owner_q;

    always_comb begin
        owner_d = owner_q;
        unique case (owner_q)
            OWN_NONE: begin
                if (smb_req)        owner_d = OWN_SMB;
                else if (host2_req) owner_d = OWN_HOST2;
            end
            OWN_SMB:   if (!smb_req)   owner_d = OWN_NONE;
            OWN_HOST2: if (!host2_req) owner_d = OWN_NONE;
            default:   owner_d = OWN_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) owner_q <= OWN_NONE;
        else        owner_q <= owner_d;
    end

    assign smb_gnt   = (owner_q == OWN_SMB);
    assign host2_gnt = (owner_q == OWN_HOST2);

    // R10: grants exclusive, no preemption, grant only from idle
    p_gnt_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(smb_gnt && host2_gnt));
    p_no_preempt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (smb_gnt && smb_req) |=> smb_gnt);
    p_host2_from_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host2_gnt) |-> !$past(smb_gnt));
    // R11: simultaneous requests favour the SMBus side
    p_tie_smb_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!smb_gnt && !host2_gnt && smb_req && host2_req) |=> smb_gnt);

endmodule

// File: rtl/smb_pbus_bridge.sv
module smb_pbus_bridge
    import smb_pbus_pkg::*;
#(
    parameter int DW         = 8,
    parameter int AW         = 4,
    parameter int NCS        = 4,
    parameter int NREGS      = 12,
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 4,
    parameter int HOLD_CYC   = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2*AW-1:0] cmd_code,
    input  logic [DW-1:0]   cmd_wdata,
    input  logic            cmd_read,
    output logic            cmd_done,
    output logic            cmd_error,
    output logic [DW-1:0]   cmd_rdata,
    input  logic            host2_req,
    output logic            host2_gnt,
    output logic [NCS-1:0]  xb_cs,
    output logic [AW-1:0]   xb_addr,
    output logic            xb_rd_n,
    output logic            xb_wr_n,
    output logic            xb_lcd_stb,
    output logic [DW-1:0]   xb_dout,
    output logic            xb_doe,
    input  logic [DW-1:0]   xb_din
);

    localparam int MAXC = (SETUP_CYC > STROBE_CYC)
                        ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                        : ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
    localparam int CW = $clog2(MAXC + 1);

    typedef struct packed {
        seq_state_e     st;
        logic [CW-1:0]  cnt;
        logic [AW-1:0]  addr;
        logic [NCS-1:0] cs;
        logic           lcd;
        logic           rd;
        logic [DW-1:0]  wdata;
        logic [DW-1:0]  rdata;
        logic           done;
        logic           err;
    } seq_t;

    seq_t s_d, s_q;

    target_e        dec_target;
    logic           dec_lcd;
    logic [NCS-1:0] dec_cs;
    logic [AW-1:0]  dec_idx;
    logic           bus_enable;
    logic [DW-1:0]  reg_rd_data;
    logic           reg_we;
    logic           smb_req;
    logic           smb_gnt;

    smb_cmd_decode #(
        .AW(AW), .NCS(NCS), .NREGS(NREGS)
    ) u_decode (
        .code       (cmd_code),
        .is_read    (cmd_read),
        .bus_enable (bus_enable),
        .target     (dec_target),
        .lcd_mode   (dec_lcd),
        .cs_onehot  (dec_cs),
        .index      (dec_idx)
    );

    smb_ctrl_regs #(
        .DW(DW), .AW(AW), .NREGS(NREGS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_we),
        .wr_idx     (dec_idx),
        .wr_data    (cmd_wdata),
        .rd_idx     (dec_idx),
        .rd_data    (reg_rd_data),
        .bus_enable (bus_enable)
    );

    smb_bus_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .smb_req   (smb_req),
        .host2_req (host2_req),
        .smb_gnt   (smb_gnt),
        .host2_gnt (host2_gnt)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        reg_we   = 1'b0;
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (cmd_valid) begin
                    unique case (dec_target)
                        TGT_REGS: begin
                            s_d.done  = 1'b1;
                            s_d.rdata = cmd_read ? reg_rd_data : '0;
                            reg_we    = !cmd_read;
                        end
                        TGT_BUS: begin
                            s_d.st    = SEQ_WAIT;
                            s_d.cnt   = '0;
                            s_d.addr  = dec_idx;
                            s_d.cs    = dec_cs;
                            s_d.lcd   = dec_lcd;
                            s_d.rd    = cmd_read;
                            s_d.wdata = cmd_wdata;
                        end
                        default: begin
                            s_d.done = 1'b1;
                            s_d.err  = 1'b1;
                        end
                    endcase
                end
            end
            SEQ_WAIT: begin
                if (smb_gnt) begin
                    s_d.st  = SEQ_SETUP;
                    s_d.cnt = '0;
                end
            end
            SEQ_SETUP: begin
                if (int'(s_q.cnt) == SETUP_CYC - 1) begin
                    s_d.st  = SEQ_STROBE;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SEQ_STROBE: begin
                if (int'(s_q.cnt) == STROBE_CYC - 1) begin
                    if (s_q.rd) s_d.rdata = xb_din;
                    s_d.st  = SEQ_HOLD;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SEQ_HOLD: begin
                if (int'(s_q.cnt) == HOLD_CYC - 1) begin
                    s_d.st   = SEQ_IDLE;
                    s_d.cnt  = '0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= SEQ_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    logic on_bus;
    logic strobing;

    assign on_bus   = (s_q.st == SEQ_SETUP) || (s_q.st == SEQ_STROBE) || (s_q.st == SEQ_HOLD);
    assign strobing = (s_q.st == SEQ_STROBE);
    assign smb_req  = (s_q.st != SEQ_IDLE);

    assign xb_cs      = on_bus ? s_q.cs : '0;
    assign xb_addr    = on_bus ? s_q.addr : '0;
    assign xb_rd_n    = !(strobing && s_q.rd);
    assign xb_wr_n    = !(strobing && !s_q.rd);
    assign xb_lcd_stb = strobing && s_q.lcd;
    assign xb_doe     = on_bus && !s_q.rd;
    assign xb_dout    = xb_doe ? s_q.wdata : '0;

    assign cmd_done  = s_q.done;
    assign cmd_error = s_q.err;
    assign cmd_rdata = s_q.rdata;

    // R9: chip selects one-hot or idle; strobes only under a chip select
    p_cs_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(xb_cs));
    p_strobe_needs_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!xb_rd_n || !xb_wr_n) |-> (xb_cs != '0));
    p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!xb_rd_n && !xb_wr_n));
    // R8: data bus never driven alongside a read strobe, nor without chip select
    p_doe_not_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xb_doe |-> (xb_rd_n && xb_cs != '0));
    // R10: SMBus cycles only while granted
    p_cs_only_granted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xb_cs != '0) |-> (smb_gnt && !host2_gnt));
    // R4: display strobe only together with a bus strobe
    p_lcd_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xb_lcd_stb |-> (!xb_rd_n || !xb_wr_n));
    // R2: error flag only ever accompanies completion
    p_err_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_error |-> cmd_done);
    // R7: address held steady while chip select stays asserted
    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((xb_cs != '0) && $past(xb_cs != '0)) |-> $stable(xb_addr));

endmodule

// File: tb/smb_pbus_bridge_test.sv
module smb_pbus_bridge_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = '0;
    logic [7:0] cmd_wdata = '0;
    logic       cmd_read = 1'b0;
    logic       cmd_done, cmd_error;
    logic [7:0] cmd_rdata;
    logic       host2_req = 1'b0;
    logic       host2_gnt;
    logic [3:0] xb_cs, xb_addr;
    logic       xb_rd_n, xb_wr_n, xb_lcd_stb, xb_doe;
    logic [7:0] xb_dout;
    logic [7:0] xb_din = '0;

    always #2 clk = ~clk;

    smb_pbus_bridge uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_wdata(cmd_wdata),
        .cmd_read(cmd_read), .cmd_done(cmd_done), .cmd_error(cmd_error),
        .cmd_rdata(cmd_rdata), .host2_req(host2_req), .host2_gnt(host2_gnt),
        .xb_cs(xb_cs), .xb_addr(xb_addr), .xb_rd_n(xb_rd_n), .xb_wr_n(xb_wr_n),
        .xb_lcd_stb(xb_lcd_stb), .xb_dout(xb_dout), .xb_doe(xb_doe), .xb_din(xb_din)
    );

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] model [12];

    int         o_setup, o_strobe, o_hold, o_cyc;
    logic [3:0] o_cs, o_addr;
    logic       o_bad, o_done, o_err, o_h2;
    logic [7:0] o_rdata;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Observe the bus at negative edges until completion.
    task automatic watch(input logic [7:0] code, input logic [7:0] data, input bit rd,
                         input int limit);
        bit exp_lcd = (code[7:4] == 4'h1);
        bit first = 1'b1;
        o_setup = 0; o_strobe = 0; o_hold = 0; o_cyc = 0;
        o_cs = '0; o_addr = '0; o_bad = 1'b0; o_done = 1'b0; o_err = 1'b0;
        o_h2 = 1'b0; o_rdata = '0;
        for (int k = 0; k < limit; k++) begin
            bit str = !xb_rd_n || !xb_wr_n;
            if (host2_gnt) o_h2 = 1'b1;
            if (xb_cs != '0) begin
                o_cyc++;
                if (first) begin o_cs = xb_cs; o_addr = xb_addr; first = 1'b0; end
                else if (xb_cs != o_cs || xb_addr != o_addr) o_bad = 1'b1;
                if (str) begin
                    o_strobe++;
                    if (o_hold > 0) o_bad = 1'b1;
                    if ((!xb_rd_n && !rd) || (!xb_wr_n && rd)) o_bad = 1'b1;
                    if (xb_lcd_stb != exp_lcd) o_bad = 1'b1;
                end else if (o_strobe == 0) o_setup++;
                else o_hold++;
                if (!rd && (!xb_doe || xb_dout != data)) o_bad = 1'b1;
            end else if (str) o_bad = 1'b1;
            if (xb_lcd_stb && !str) o_bad = 1'b1;
            if (xb_doe && (rd || xb_cs == '0)) o_bad = 1'b1;
            xb_din = (str && o_strobe == 4) ? ~code : 8'h00;
            if (cmd_done) begin
                o_done = 1'b1; o_err = cmd_error; o_rdata = cmd_rdata;
                break;
            end
            @(negedge clk);
        end
        xb_din = 8'h00;
    endtask

    task automatic start(input logic [7:0] code, input logic [7:0] data, input bit rd);
        @(negedge clk);
        cmd_code = code; cmd_wdata = data; cmd_read = rd; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic txn(input logic [7:0] code, input logic [7:0] data, input bit rd);
        logic [3:0] hi = code[7:4];
        logic [3:0] lo = code[3:0];
        start(code, data, rd);
        watch(code, data, rd, 100);
        chk(o_done, "R7", "completion seen", o_done, 1);
        if (hi == 4'h0 && lo < 4'd12) begin
            chk(!o_err && o_cyc == 0, "R1", $sformatf("reg access %02h", code), {o_err, 8'(o_cyc)}, 0);
            if (rd) chk(o_rdata == model[lo], "R1", $sformatf("reg read %02h", code), o_rdata, model[lo]);
            else model[lo] = data;
        end else if (hi == 4'h0) begin
            chk(o_err && o_cyc == 0, "R2", $sformatf("bad index %02h", code), {o_err, 8'(o_cyc)}, 256);
        end else if (hi == 4'h1 && lo[0] != rd) begin
            chk(o_err && o_cyc == 0, "R5", $sformatf("direction mismatch %02h rd=%0d", code, rd),
                {o_err, 8'(o_cyc)}, 256);
        end else if (hi >= 4'h1 && hi <= 4'h5) begin
            logic [3:0] ecs = (hi == 4'h1) ? 4'b0010 : 4'(1 << (hi - 4'h2));
            chk(!o_err, hi == 4'h1 ? "R4" : "R3", $sformatf("no error %02h", code), o_err, 0);
            chk(o_cs == ecs && o_addr == lo, hi == 4'h1 ? "R4" : "R3",
                $sformatf("cs/addr %02h", code), {o_cs, o_addr}, {ecs, lo});
            chk(o_setup == 2 && o_strobe == 4 && o_hold == 1, "R7",
                $sformatf("phases %02h", code), o_setup * 100 + o_strobe * 10 + o_hold, 241);
            chk(!o_bad, "R8", $sformatf("strobe/data shape %02h", code), o_bad, 0);
            if (rd) chk(o_rdata == ~code, "R7", $sformatf("read capture %02h", code), o_rdata, ~code);
        end else begin
            chk(o_err && o_cyc == 0, "R6", $sformatf("undefined %02h", code), {o_err, 8'(o_cyc)}, 256);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R7 watchdog expired: actual 0 expected 1");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 12; i++) model[i] = (i == 2) ? 8'h01 : 8'h00;
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(xb_cs == 0 && xb_rd_n && xb_wr_n && !xb_doe && !xb_lcd_stb &&
            !cmd_done && !cmd_error && !host2_gnt, "R13", "reset outputs", xb_cs, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset value of enable register
        txn(8'h02, 8'h00, 1'b1);

        // Sweep every command in both directions
        for (int c = 0; c < 256; c++) begin
            for (int r = 0; r < 2; r++) begin
                txn(8'(c), {4'(c), 4'(c >> 4)} | 8'h01, r[0]);
            end
        end
        // R2: register contents unaffected by rejected indices
        for (int i = 0; i < 12; i++) txn(8'(i), 8'h00, 1'b1);

        // R12: bus access disabled via register 2
        txn(8'h02, 8'h00, 1'b0);
        start(8'h35, 8'hC3, 1'b0);
        watch(8'h35, 8'hC3, 1'b0, 50);
        chk(o_done && o_err && o_cyc == 0, "R12", "disabled generic", {o_err, 8'(o_cyc)}, 256);
        start(8'h12, 8'h11, 1'b0);
        watch(8'h12, 8'h11, 1'b0, 50);
        chk(o_done && o_err && o_cyc == 0, "R12", "disabled display", {o_err, 8'(o_cyc)}, 256);
        txn(8'h02, 8'h01, 1'b0);
        txn(8'h35, 8'hC3, 1'b0);

        // R10: second host holds the bus, SMBus command waits
        @(negedge clk); host2_req = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(host2_gnt, "R10", "idle grant to host2", host2_gnt, 1);
        start(8'h47, 8'h5A, 1'b0);
        begin
            bit leaked = 1'b0;
            for (int k = 0; k < 12; k++) begin
                if (xb_cs != 0 || cmd_done) leaked = 1'b1;
                @(negedge clk);
            end
            chk(!leaked, "R10", "no cycle while host2 owns", leaked, 0);
        end
        host2_req = 1'b0;
        watch(8'h47, 8'h5A, 1'b0, 100);
        chk(o_done && !o_err && o_cs == 4'b0100 && o_addr == 4'h7 && o_strobe == 4,
            "R10", "deferred cycle runs", {o_cs, o_addr}, 8'h47);

        // R11: same-clock tie, SMBus side wins and is not preempted
        @(negedge clk);
        cmd_code = 8'h52; cmd_wdata = 8'h00; cmd_read = 1'b1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; host2_req = 1'b1;
        @(negedge clk);
        watch(8'h52, 8'h00, 1'b1, 100);
        chk(o_done && !o_h2 && o_cyc == 7 && o_cs == 4'b1000, "R11", "tie to SMBus, no preempt",
            {o_h2, 8'(o_cyc)}, 7);
        chk(o_rdata == 8'hAD, "R7", "tie read data", o_rdata, 8'hAD);
        @(negedge clk); @(negedge clk);
        chk(host2_gnt, "R10", "host2 granted after cycle", host2_gnt, 1);
        host2_req = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(!host2_gnt && xb_cs == 0, "R10", "host2 released", host2_gnt, 0);

        finish_run();
    end

endmodule